// File: doc/BRIEF.md
# Local Interrupt Pending, Enable and Priority Arbiter

This block keeps the machine-level pending, enable and delegation state for the standard local interrupts of a hart. Those interrupts are the external, software and timer sources at machine and supervisor level, plus a counter-overflow interrupt at bit 13. Each cycle it works out which interrupt the hart should take, which privilege level that interrupt goes to, and its cause code. The result comes from a single register stage.

Hardware supplies six level sources and a vector of overflow request pulses. Software reads and writes five register views through a select code. The views are the machine pending view, the machine enable view, the delegation mask, and the supervisor pending and enable views. The supervisor views show only delegated bits.

The overflow pending bit is sticky. Any overflow pulse sets it, and only a software write clears it. It ranks lowest at every privilege level. Its delegation bit decides whether it goes to machine or supervisor level.

Top module: `lcl_irq_arb`

## Requirements
- R1: After reset, every stored pending, enable and delegation bit reads 0, and irq_valid_o is 0.
- R2: Any set bit of ovf_req_i sets pending bit 13. The bit stays set until software writes 0 to it. If an overflow pulse and a clearing write arrive in the same cycle, the bit ends up set.
- R3: When both a machine-destined and a supervisor-destined interrupt can be taken, the machine-destined one is chosen, whatever the two causes are.
- R4: Among machine-destined candidates, the cause codes rank 11, 3, 7, 9, 1, 5, 13, from highest to lowest. The cause code is the bit index.
- R5: Among supervisor-destined candidates, the cause codes rank 9, 1, 5, 13, from highest to lowest.
- R6: Delegation bits exist only at positions 1, 5, 9 and 13. A delegated interrupt is reported with irq_to_s_o=1. An undelegated one is reported with irq_to_s_o=0. Causes 3, 7 and 11 always go to machine level.
- R7: A machine-destined interrupt is taken only when it is pending and enabled, and either priv_i is not 3 or m_gie_i is 1. The priv_i codes are 0 for user, 1 for supervisor and 3 for machine.
- R8: A supervisor-destined interrupt is taken only when priv_i is 0, or when priv_i is 1 and s_gie_i is 1. It is never taken when priv_i is 3.
- R9: Select code 3 reads pending AND delegation. Select code 4 reads enable AND delegation. A write through code 4 changes only delegated enable bits. A write through code 3 changes only delegated bits among positions 1 and 13.
- R10: Select code 0 reads the live sources (bits 11, 3, 7, 9, 1, 5) ORed with the stored pending bits. A write through code 0 changes only bits 1, 5, 9 and 13.
- R11: With HAS_OVF=0, bit 13 reads 0 in both pending and enable, and 13 is never reported as a cause.
- R12: The outputs are registered. After each clock edge they reflect the sources, mode and register writes that were present at that edge.
- R13: The enable register (select code 1) holds only bits 1, 3, 5, 7, 9, 11 and 13. The delegation register (select code 2) holds only bits 1, 5, 9 and 13. Select codes 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_ext_i | input | 1 | Machine external source (bit 11) |
| m_sw_i | input | 1 | Machine software source (bit 3) |
| m_tmr_i | input | 1 | Machine timer source (bit 7) |
| s_ext_i | input | 1 | Supervisor external source (bit 9) |
| s_sw_i | input | 1 | Supervisor software source (bit 1) |
| s_tmr_i | input | 1 | Supervisor timer source (bit 5) |
| ovf_req_i | input | NUM_CNT | Counter overflow request pulses |
| priv_i | input | 2 | Current privilege mode |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 3 | Register view select |
| csr_wdata_i | input | 16 | Write data |
| csr_rdata_o | output | 16 | Read data of the selected view |
| irq_valid_o | output | 1 | An interrupt is to be taken |
| irq_cause_o | output | 4 | Cause code (bit index) |
| irq_to_s_o | output | 1 | 1 when the interrupt goes to supervisor level |

## Verification
The bench builds two copies of the block. The first uses the defaults: four overflow lines, with both supervisor interrupts and the overflow interrupt present. This copy covers the full priority ladders, delegation in both directions and the masking of the supervisor views. The second copy has HAS_OVF=0 and is driven by the same stimulus. It shows that bit 13 stays absent from pending, enable and cause while the first copy records overflows.

// File: rtl/lcl_irq_pkg.sv
package lcl_irq_pkg;
    localparam int RW = 16;
    localparam int CW = 4;

    localparam int B_SSW = 1;
    localparam int B_MSW = 3;
    localparam int B_STM = 5;
    localparam int B_MTM = 7;
    localparam int B_SEX = 9;
    localparam int B_MEX = 11;
    localparam int B_OVF = 13;

    localparam int PRIO_N = 7;
    // highest priority first; the supervisor-level ladder is the tail of this list
    localparam logic [CW-1:0] PRIO [PRIO_N] = '{4'd11, 4'd3, 4'd7, 4'd9, 4'd1, 4'd5, 4'd13};

    typedef enum logic [2:0] {
        SEL_MPEND = 3'd0,
        SEL_MEN   = 3'd1,
        SEL_DELEG = 3'd2,
        SEL_SPEND = 3'd3,
        SEL_SEN   = 3'd4
    } csr_sel_e;

    typedef struct packed {
        logic [RW-1:0] swp;
        logic [RW-1:0] en;
        logic [RW-1:0] deleg;
        logic          v;
        logic [CW-1:0] cause;
        logic          to_s;
    } arb_state_t;

    function automatic logic [RW-1:0] bitv(input int idx);
        return RW'(1) << idx;
    endfunction
endpackage

// File: rtl/lcl_irq_pick.sv
module lcl_irq_pick
    import lcl_irq_pkg::*;
(
    input  logic [RW-1:0] cand_i,
    output logic          hit_o,
    output logic [CW-1:0] cause_o
);
    always_comb begin
        hit_o   = 1'b0;
        cause_o = '0;
        // walk from lowest to highest priority; later matches override
        for (int i = PRIO_N - 1; i >= 0; i--) begin
            if (cand_i[PRIO[i]]) begin
                hit_o   = 1'b1;
                cause_o = PRIO[i];
            end
        end
    end
endmodule

// File: rtl/lcl_irq_view.sv
module lcl_irq_view
    import lcl_irq_pkg::*;
#(
    parameter logic [RW-1:0] MP_WR = '0,
    parameter logic [RW-1:0] SP_WR = '0,
    parameter logic [RW-1:0] EN_WR = '0,
    parameter logic [RW-1:0] DG_WR = '0
) (
    input  csr_sel_e      sel_i,
    input  logic          we_i,
    input  logic [RW-1:0] wdata_i,
    input  logic [RW-1:0] pend_live_i,
    input  logic [RW-1:0] swp_q_i,
    input  logic [RW-1:0] en_q_i,
    input  logic [RW-1:0] deleg_q_i,
    output logic [RW-1:0] rdata_o,
    output logic [RW-1:0] swp_w_o,
    output logic [RW-1:0] en_w_o,
    output logic [RW-1:0] deleg_w_o
);
    logic [RW-1:0] sp_mask;
    logic [RW-1:0] se_mask;

    assign sp_mask = SP_WR & deleg_q_i;
    assign se_mask = DG_WR & deleg_q_i;

    always_comb begin
        case (sel_i)
            SEL_MPEND: rdata_o = pend_live_i;
            SEL_MEN:   rdata_o = en_q_i;
            SEL_DELEG: rdata_o = deleg_q_i;
            SEL_SPEND: rdata_o = pend_live_i & deleg_q_i;
            SEL_SEN:   rdata_o = en_q_i & deleg_q_i;
            default:   rdata_o = '0;
        endcase
    end

    always_comb begin
        swp_w_o   = swp_q_i;
        en_w_o    = en_q_i;
        deleg_w_o = deleg_q_i;
        if (we_i) begin
            case (sel_i)
                SEL_MPEND: swp_w_o   = (swp_q_i & ~MP_WR) | (wdata_i & MP_WR);
                SEL_SPEND: swp_w_o   = (swp_q_i & ~sp_mask) | (wdata_i & sp_mask);
                SEL_MEN:   en_w_o    = (en_q_i & ~EN_WR) | (wdata_i & EN_WR);
                SEL_SEN:   en_w_o    = (en_q_i & ~se_mask) | (wdata_i & se_mask);
                SEL_DELEG: deleg_w_o = (deleg_q_i & ~DG_WR) | (wdata_i & DG_WR);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lcl_irq_arb.sv
module lcl_irq_arb
    import lcl_irq_pkg::*;
#(
    parameter int NUM_CNT   = 4,
    parameter bit HAS_OVF   = 1'b1,
    parameter bit HAS_SUPER = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               m_ext_i,
    input  logic               m_sw_i,
    input  logic               m_tmr_i,
    input  logic               s_ext_i,
    input  logic               s_sw_i,
    input  logic               s_tmr_i,
    input  logic [NUM_CNT-1:0] ovf_req_i,
    input  logic [1:0]         priv_i,
    input  logic               m_gie_i,
    input  logic               s_gie_i,
    input  logic               csr_we_i,
    input  logic [2:0]         csr_sel_i,
    input  logic [RW-1:0]      csr_wdata_i,
    output logic [RW-1:0]      csr_rdata_o,
    output logic               irq_valid_o,
    output logic [CW-1:0]      irq_cause_o,
    output logic               irq_to_s_o
);
    localparam logic [RW-1:0] M_BITS = bitv(B_MSW) | bitv(B_MTM) | bitv(B_MEX);
    localparam logic [RW-1:0] S_BITS = HAS_SUPER ? (bitv(B_SSW) | bitv(B_STM) | bitv(B_SEX)) : '0;
    localparam logic [RW-1:0] O_BITS = HAS_OVF ? bitv(B_OVF) : '0;
    localparam logic [RW-1:0] ALL    = M_BITS | S_BITS | O_BITS;
    localparam logic [RW-1:0] DG_WR  = S_BITS | O_BITS;
    localparam logic [RW-1:0] SP_WR  = (HAS_SUPER ? bitv(B_SSW) : '0) | O_BITS;
    localparam logic [1:0]    PRIV_U = 2'd0;
    localparam logic [1:0]    PRIV_S = 2'd1;
    localparam logic [1:0]    PRIV_M = 2'd3;

    arb_state_t st_d, st_q;

    logic [RW-1:0] src, pend_live, pend_nx;
    logic [RW-1:0] swp_w, en_w, deleg_w, swp_nx;
    logic [1:0][RW-1:0] cand;
    logic [1:0]          hit;
    logic [1:0][CW-1:0]  pcause;
    logic                m_ok, s_ok;

    always_comb begin
        src        = '0;
        src[B_MEX] = m_ext_i;
        src[B_MSW] = m_sw_i;
        src[B_MTM] = m_tmr_i;
        src[B_SEX] = s_ext_i;
        src[B_SSW] = s_sw_i;
        src[B_STM] = s_tmr_i;
        src        = src & ALL;
    end

    assign pend_live = (st_q.swp | src) & ALL;

    lcl_irq_view #(
        .MP_WR(DG_WR),
        .SP_WR(SP_WR),
        .EN_WR(ALL),
        .DG_WR(DG_WR)
    ) u_view (
        .sel_i      (csr_sel_e'(csr_sel_i)),
        .we_i       (csr_we_i),
        .wdata_i    (csr_wdata_i),
        .pend_live_i(pend_live),
        .swp_q_i    (st_q.swp),
        .en_q_i     (st_q.en),
        .deleg_q_i  (st_q.deleg),
        .rdata_o    (csr_rdata_o),
        .swp_w_o    (swp_w),
        .en_w_o     (en_w),
        .deleg_w_o  (deleg_w)
    );

    // an overflow pulse is applied after the write so that it wins
    assign swp_nx  = (swp_w | ((|ovf_req_i) ? O_BITS : '0)) & DG_WR;
    assign pend_nx = (swp_nx | src) & ALL;

    assign m_ok = (priv_i != PRIV_M) || m_gie_i;
    assign s_ok = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && s_gie_i);

    assign cand[0] = pend_nx & en_w & ~deleg_w & {RW{m_ok}};
    assign cand[1] = pend_nx & en_w &  deleg_w & {RW{s_ok}};

    for (genvar g = 0; g < 2; g++) begin : g_pick
        lcl_irq_pick u_pick (
            .cand_i (cand[g]),
            .hit_o  (hit[g]),
            .cause_o(pcause[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.swp   = swp_nx;
        st_d.en    = en_w & ALL;
        st_d.deleg = deleg_w & DG_WR;
        st_d.v     = hit[0] | hit[1];
        st_d.to_s  = !hit[0] && hit[1];
        st_d.cause = hit[0] ? pcause[0] : (hit[1] ? pcause[1] : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_valid_o = st_q.v;
    assign irq_cause_o = st_q.cause;
    assign irq_to_s_o  = st_q.to_s;
endmodule

// File: rtl/lcl_irq_arb_chk.sv
module lcl_irq_arb_chk
    import lcl_irq_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter bit HAS_OVF = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CNT-1:0] ovf_req_i,
    input logic [1:0]         priv_i,
    input logic               m_gie_i,
    input logic               irq_valid_o,
    input logic [CW-1:0]      irq_cause_o,
    input logic               irq_to_s_o,
    input logic [RW-1:0]      pend_live
);
    a_r4_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (irq_cause_o inside {4'd1, 4'd3, 4'd5, 4'd7, 4'd9, 4'd11, 4'd13}));

    a_r2_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ovf_req_i) && HAS_OVF) |=> pend_live[B_OVF]);

    a_r8_no_s_in_m: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_to_s_o) |-> ($past(priv_i) != 2'd3));

    a_r7_m_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && !irq_to_s_o) |-> (($past(priv_i) != 2'd3) || $past(m_gie_i)));

    a_r6_m_only_causes: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && (irq_cause_o inside {4'd3, 4'd7, 4'd11})) |-> !irq_to_s_o);

    a_r11_no_absent_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_OVF) |-> !(irq_valid_o && irq_cause_o == 4'd13) && !pend_live[B_OVF]);
endmodule

bind lcl_irq_arb lcl_irq_arb_chk #(.NUM_CNT(NUM_CNT), .HAS_OVF(HAS_OVF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovf_req_i  (ovf_req_i),
    .priv_i     (priv_i),
    .m_gie_i    (m_gie_i),
    .irq_valid_o(irq_valid_o),
    .irq_cause_o(irq_cause_o),
    .irq_to_s_o (irq_to_s_o),
    .pend_live  (pend_live)
);

// File: tb/tb_lcl_irq_arb.sv
module tb_lcl_irq_arb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_ext = 0, m_sw = 0, m_tmr = 0, s_ext = 0, s_sw = 0, s_tmr = 0;
    logic [3:0] ovf = '0;
    logic [1:0] priv = 2'd3;
    logic m_gie = 0, s_gie = 0, we = 0;
    logic [2:0] sel = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rd, rd2;
    logic v, v2, to_s, to_s2;
    logic [3:0] cause, cause2;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lcl_irq_arb dut (
        .clk(clk), .rst_n(rst_n), .m_ext_i(m_ext), .m_sw_i(m_sw), .m_tmr_i(m_tmr),
        .s_ext_i(s_ext), .s_sw_i(s_sw), .s_tmr_i(s_tmr), .ovf_req_i(ovf),
        .priv_i(priv), .m_gie_i(m_gie), .s_gie_i(s_gie), .csr_we_i(we),
        .csr_sel_i(sel), .csr_wdata_i(wdata), .csr_rdata_o(rd),
        .irq_valid_o(v), .irq_cause_o(cause), .irq_to_s_o(to_s)
    );

    lcl_irq_arb #(.HAS_OVF(1'b0)) dut_nov (
        .clk(clk), .rst_n(rst_n), .m_ext_i(m_ext), .m_sw_i(m_sw), .m_tmr_i(m_tmr),
        .s_ext_i(s_ext), .s_sw_i(s_sw), .s_tmr_i(s_tmr), .ovf_req_i(ovf),
        .priv_i(priv), .m_gie_i(m_gie), .s_gie_i(s_gie), .csr_we_i(we),
        .csr_sel_i(sel), .csr_wdata_i(wdata), .csr_rdata_o(rd2),
        .irq_valid_o(v2), .irq_cause_o(cause2), .irq_to_s_o(to_s2)
    );

    typedef struct {
        bit          ci;
        bit          ev;
        logic [3:0]  ec;
        bit          es;
        bit          cr;
        logic [15:0] erd;
        bit          c2;
        bit          ev2;
        logic [15:0] erd2;
        string       tag;
    } exp_t;

    exp_t sb[$];

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // wait for the falling edge, drop the one-cycle strobes
    task automatic cyc();
        @(negedge clk);
        we  = 1'b0;
        ovf = '0;
    endtask

    task automatic expect_irq(input bit ev, input int ec, input bit es, input string tag);
        exp_t e;
        e = '{ci: 1, ev: ev, ec: 4'(ec), es: es, cr: 0, erd: '0, c2: 0, ev2: 0, erd2: '0, tag: tag};
        sb.push_back(e);
    endtask

    task automatic expect_all(input bit ev, input int ec, input bit es, input int erd, input string tag);
        exp_t e;
        e = '{ci: 1, ev: ev, ec: 4'(ec), es: es, cr: 1, erd: 16'(erd), c2: 0, ev2: 0, erd2: '0, tag: tag};
        sb.push_back(e);
    endtask

    task automatic expect_nov(input bit ev, input int ec, input bit es, input int erd,
                              input bit ev2, input int erd2, input string tag);
        exp_t e;
        e = '{ci: 1, ev: ev, ec: 4'(ec), es: es, cr: 1, erd: 16'(erd), c2: 1, ev2: ev2,
              erd2: 16'(erd2), tag: tag};
        sb.push_back(e);
    endtask

    // monitor: just after each rising edge, compare against the next queued item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                if (e.ci) begin
                    cmp(e.tag, "valid", int'(v), int'(e.ev));
                    if (e.ev) begin
                        cmp(e.tag, "cause", int'(cause), int'(e.ec));
                        cmp(e.tag, "to_s", int'(to_s), int'(e.es));
                    end
                end
                if (e.cr) cmp(e.tag, "rdata", int'(rd), int'(e.erd));
                if (e.c2) begin
                    cmp(e.tag, "nov valid", int'(v2), int'(e.ev2));
                    cmp(e.tag, "nov rdata", int'(rd2), int'(e.erd2));
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cyc(); sel = 3'd0; expect_nov(0, 0, 0, 16'h0000, 0, 16'h0000, "R1 pending");
        cyc(); sel = 3'd1; expect_all(0, 0, 0, 16'h0000, "R1 enable");
        cyc(); sel = 3'd2; expect_all(0, 0, 0, 16'h0000, "R1 deleg");

        // R13: enable register keeps only the interrupt bits
        cyc(); we = 1; sel = 3'd1; wdata = 16'hFFFF;
        expect_nov(0, 0, 0, 16'h2AAA, 0, 16'h0AAA, "R13 enable mask / R11");

        // R2 R7: overflow pulse sets bit 13, but machine mode with gie off blocks it
        cyc(); ovf = 4'b0100; sel = 3'd0;
        expect_nov(0, 0, 0, 16'h2000, 0, 16'h0000, "R2 R7 R11 ovf set, gated");
        // R12: taken in the cycle after the enable is applied
        cyc(); m_gie = 1;
        expect_nov(1, 13, 0, 16'h2000, 0, 16'h0000, "R6 R7 R12 ovf to M");

        // R4: machine-level ladder
        cyc(); m_tmr = 1; expect_all(1, 7, 0, 16'h2080, "R4 MT over ovf");
        cyc(); s_sw = 1; s_tmr = 1; expect_irq(1, 7, 0, "R4 MT over S bits");
        cyc(); m_tmr = 0; expect_irq(1, 1, 0, "R4 SS over ST");
        cyc(); s_ext = 1; expect_irq(1, 9, 0, "R4 SE over SS");
        cyc(); m_sw = 1; expect_irq(1, 3, 0, "R4 MS over SE");
        cyc(); m_ext = 1; expect_all(1, 11, 0, 16'h2A2A, "R4 ME top R10 live");
        cyc(); m_ext = 0; m_sw = 0; s_ext = 0; s_sw = 0; s_tmr = 0;
        expect_irq(1, 13, 0, "R2 sticky");

        // R10: hardware-owned machine bits ignore writes
        cyc(); we = 1; sel = 3'd0; wdata = 16'h2888;
        expect_all(1, 13, 0, 16'h2000, "R10 write mask");

        // R13 delegation mask, R8 no supervisor interrupt in M
        cyc(); we = 1; sel = 3'd2; wdata = 16'hFFFF;
        expect_nov(0, 0, 0, 16'h2222, 0, 16'h0222, "R13 deleg mask R8");
        cyc(); sel = 3'd5; expect_all(0, 0, 0, 16'h0000, "R13 unused select");

        // R8 R9: supervisor mode
        cyc(); priv = 2'd1; s_gie = 0; sel = 3'd3;
        expect_all(0, 0, 0, 16'h2000, "R8 S gie off R9 view");
        cyc(); s_gie = 1; expect_irq(1, 13, 1, "R6 R8 ovf to S");
        cyc(); m_tmr = 1; s_ext = 1; expect_irq(1, 7, 0, "R3 M over S");
        cyc(); m_tmr = 0; expect_irq(1, 9, 1, "R5 SE");
        cyc(); s_ext = 0; s_tmr = 1; expect_irq(1, 5, 1, "R5 ST over ovf");
        cyc(); s_sw = 1; expect_irq(1, 1, 1, "R5 SS over ST");
        cyc(); s_sw = 0; s_tmr = 0; expect_irq(1, 13, 1, "R5 ovf last");

        // R8: user mode always takes supervisor-destined
        cyc(); priv = 2'd0; s_gie = 0; sel = 3'd4;
        expect_all(1, 13, 1, 16'h2222, "R8 user R9 sie view");

        // R6: undelegate bit 13
        cyc(); we = 1; sel = 3'd2; wdata = 16'h0222;
        expect_all(1, 13, 0, 16'h0222, "R6 ovf back to M");
        cyc(); sel = 3'd3; expect_all(1, 13, 0, 16'h0000, "R9 sip hides undelegated");
        cyc(); we = 1; sel = 3'd3; wdata = 16'h0000;
        expect_all(1, 13, 0, 16'h0000, "R9 sip write ignored");
        cyc(); sel = 3'd0; expect_all(1, 13, 0, 16'h2000, "R9 pending kept");
        cyc(); we = 1; sel = 3'd4; wdata = 16'h0000; expect_irq(1, 13, 0, "R9 sie write");
        cyc(); sel = 3'd1; expect_all(1, 13, 0, 16'h2888, "R9 sie touched only delegated");

        // R2: set wins over a clearing write, then a clear alone works
        cyc(); we = 1; sel = 3'd0; wdata = 16'h0000; ovf = 4'b0001;
        expect_all(1, 13, 0, 16'h2000, "R2 set wins");
        cyc(); we = 1; sel = 3'd0; wdata = 16'h0000;
        expect_all(0, 0, 0, 16'h0000, "R2 cleared");

        // R10 R9: software-set supervisor software pending, then enable it
        cyc(); we = 1; sel = 3'd0; wdata = 16'h0002;
        expect_all(0, 0, 0, 16'h0002, "R10 ssip write");
        cyc(); we = 1; sel = 3'd1; wdata = 16'h0002;
        expect_all(1, 1, 1, 16'h0002, "R5 R6 ss delegated");

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule